// File: doc/BRIEF.md
# Bi-phase Bit Decoder with Preamble Synchronisation

This block recovers data bits from a single-bit amplitude envelope that carries a 2 kbit/s differential bi-phase code. The raw envelope is first synchronised into the system clock domain. A debounce filter removes pulses shorter than a few microseconds. A prescaler derives a 1 µs tick from the system clock. Each accepted level change ends one interval, and the block measures that interval in microseconds. An interval of about 250 µs is a half cell and an interval of about 500 µs is a full cell. Two half cells in a row give a ONE, and one full cell gives a ZERO.

While the block is hunting, it counts preamble ONEs. It locks onto a frame when a ZERO follows a long enough run of ONEs. That ZERO is the start bit of the first byte. From the start bit onward, every decoded bit is delivered as a one-cycle strobe with its value. If an edge arrives outside the timing windows, the block leaves the frame and hunts again. It does the same after more than 800 µs without a transition. Both cases raise a one-cycle sync-loss pulse. Byte framing, parity and packet checks belong to the logic downstream.

The state machine has five states:

- `S_WAIT_EDGE`: idle until the first transition.
- `S_PRE_CELL`: hunting, at a cell boundary.
- `S_PRE_MID`: hunting, with half of a ONE pending.
- `S_DATA_CELL`: in frame, at a cell boundary.
- `S_DATA_MID`: in frame, with half of a ONE pending.

Its transitions are:

- **first-edge**: `S_WAIT_EDGE` to `S_PRE_CELL`.
- **half-open**: a half interval at a boundary. `S_PRE_CELL` goes to `S_PRE_MID`, and `S_DATA_CELL` goes to `S_DATA_MID`.
- **half-close**: a half interval while a half is pending. The block counts or emits a ONE and returns to the matching cell state.
- **zero-short**: a full interval in `S_PRE_CELL` with too few ONEs. The ONE count is cleared and the state stays `S_PRE_CELL`.
- **frame-lock**: a full interval in `S_PRE_CELL` with enough ONEs. The state goes to `S_DATA_CELL`.
- **data-zero**: a full interval in `S_DATA_CELL`. The block emits a ZERO.
- **violation**: a bad interval, or a full interval while a half is pending. The state goes to `S_PRE_CELL`.
- **silence**: a timeout in any state other than `S_WAIT_EDGE`. The state goes to `S_WAIT_EDGE`.

Top module: `biphase_sync_decoder`

## Requirements
- R1: After reset, `bit_valid`, `frame_start`, `sync_lost` and `in_frame` are all 0, and the decoder is waiting for a first transition.
- R2: An edge-to-edge interval of 200 to 300 µs inclusive is a half cell. An interval of 400 to 600 µs inclusive is a full cell. While in frame, two consecutive half cells produce one `bit_valid` pulse with `bit_value`=1, and one full cell produces one pulse with `bit_value`=0. Bits are delivered in arrival order.
- R3: A full cell that follows at least MIN_PRE_ONES (default 4) counted preamble ONEs raises `frame_start` for one cycle. In that same cycle the block emits the start bit as `bit_valid`=1 with `bit_value`=0, and `in_frame` becomes 1. Preambles of 4 to 25 ONEs are accepted.
- R4: A full cell that follows fewer than MIN_PRE_ONES ONEs gives no `frame_start`, no bit and no `sync_lost`. It clears the ONE count, so a later start bit needs a fresh run of ONEs.
- R5: An interval that lies outside both windows (for example 350 µs) raises `sync_lost` for one cycle, drops `in_frame`, and emits no bit.
- R6: A full-cell interval that arrives while the first half of a ONE is pending is a violation and behaves as in R5.
- R7: When more than 800 µs pass without a transition after a first edge, the block pulses `sync_lost` once, clears `in_frame` and waits for a new first edge. With no edge at all since reset, no `sync_lost` is raised.
- R8: An input pulse shorter than FILT_TICKS µs (default 3) is not a transition and does not change the decoded bits.
- R9: Intervals scaled by ±4% from nominal (240/480 µs and 260/520 µs) decode correctly.
- R10: Preamble ONEs are never emitted. `bit_valid` is 1 only while `in_frame` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| env_in | input | 1 | Raw envelope level, asynchronous to `clk` |
| bit_valid | output | 1 | One-cycle strobe: a decoded bit is present |
| bit_value | output | 1 | Decoded bit value, qualified by `bit_valid` |
| frame_start | output | 1 | One-cycle pulse on the start bit after a valid preamble |
| sync_lost | output | 1 | One-cycle pulse on a timing violation or on silence |
| in_frame | output | 1 | High from the start bit until the next sync loss |

## Verification
The bound checker tests, on every cycle, the relations among the outputs:

- `frame_start` always coincides with a ZERO strobe and is entered from outside a frame.
- A bit strobe never appears outside a frame and never lasts two cycles.
- A sync-loss pulse leaves the frame with no bit emitted.

The bench scenarios are needed for the behaviour that depends on timing:

- where the half and full windows lie, including ±4% rate drift and window edges;
- the minimum preamble count and the clearing of that count by an early ZERO;
- the full-while-pending violation;
- the 800 µs silence timeout and its absence before the first edge;
- rejection of short glitches.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

    typedef enum logic [2:0] {
        S_WAIT_EDGE,
        S_PRE_CELL,
        S_PRE_MID,
        S_DATA_CELL,
        S_DATA_MID
    } bpd_state_e;

    typedef enum logic [1:0] {
        IV_HALF,
        IV_FULL,
        IV_BAD
    } bpd_iv_e;

    // Windows are inclusive on both ends.
    function automatic bpd_iv_e bpd_classify(
        input int unsigned t,
        input int unsigned hmin,
        input int unsigned hmax,
        input int unsigned fmin,
        input int unsigned fmax
    );
        if (t >= hmin && t <= hmax)
            return IV_HALF;
        else if (t >= fmin && t <= fmax)
            return IV_FULL;
        else
            return IV_BAD;
    endfunction

endpackage

// File: rtl/bpd_timebase.sv
module bpd_timebase #(
    parameter int unsigned CLK_PER_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic us_tick
);
    generate
        if (CLK_PER_US <= 1) begin : g_direct
            assign us_tick = rst_n;
        end else begin : g_div
            localparam int unsigned PW = $clog2(CLK_PER_US);
            localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);
            logic [PW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q   <= '0;
                    us_tick <= 1'b0;
                end else if (div_q == LAST) begin
                    div_q   <= '0;
                    us_tick <= 1'b1;
                end else begin
                    div_q   <= div_q + 1'b1;
                    us_tick <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bpd_input_cond.sv
module bpd_input_cond #(
    parameter int unsigned FILT_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic raw_in,
    output logic clean_lvl,
    output logic edge_pulse
);
    localparam int unsigned FW = (FILT_TICKS > 1) ? $clog2(FILT_TICKS) : 1;
    localparam logic [FW-1:0] FLAST = FW'(FILT_TICKS - 1);

    logic          meta_q;
    logic          sync_q;
    logic [FW-1:0] stab_q;

    // Two-stage synchroniser.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
        end
    end

    // A new level is accepted only after FILT_TICKS consecutive ticks
    // that disagree with the accepted level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stab_q     <= '0;
            clean_lvl  <= 1'b0;
            edge_pulse <= 1'b0;
        end else begin
            edge_pulse <= 1'b0;
            if (sync_q == clean_lvl) begin
                stab_q <= '0;
            end else if (us_tick) begin
                if (stab_q == FLAST) begin
                    clean_lvl  <= sync_q;
                    stab_q     <= '0;
                    edge_pulse <= 1'b1;
                end else begin
                    stab_q <= stab_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bpd_interval_timer.sv
module bpd_interval_timer
    import bpd_pkg::*;
#(
    parameter int unsigned HALF_MIN_US = 200,
    parameter int unsigned HALF_MAX_US = 300,
    parameter int unsigned FULL_MIN_US = 400,
    parameter int unsigned FULL_MAX_US = 600,
    parameter int unsigned SILENCE_US  = 800
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    us_tick,
    input  logic    edge_in,
    output bpd_iv_e iv_class,
    output logic    timeout
);
    localparam int unsigned CW = $clog2(SILENCE_US + 2);
    localparam logic [CW-1:0] SIL  = CW'(SILENCE_US);
    localparam logic [CW-1:0] SATV = CW'(SILENCE_US + 1);

    logic [CW-1:0] age_q;

    // Microseconds since the last accepted edge; saturates past the limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q   <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (edge_in) begin
                age_q <= '0;
            end else if (us_tick && age_q != SATV) begin
                age_q <= age_q + 1'b1;
                if (age_q == SIL)
                    timeout <= 1'b1;
            end
        end
    end

    assign iv_class = bpd_classify(32'(age_q), HALF_MIN_US, HALF_MAX_US,
                                   FULL_MIN_US, FULL_MAX_US);
endmodule

// File: rtl/biphase_sync_decoder.sv
module biphase_sync_decoder
    import bpd_pkg::*;
#(
    parameter int unsigned CLK_PER_US    = 200,
    parameter int unsigned FILT_TICKS    = 3,
    parameter int unsigned HALF_MIN_US   = 200,
    parameter int unsigned HALF_MAX_US   = 300,
    parameter int unsigned FULL_MIN_US   = 400,
    parameter int unsigned FULL_MAX_US   = 600,
    parameter int unsigned SILENCE_US    = 800,
    parameter int unsigned MIN_PRE_ONES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic env_in,
    output logic bit_valid,
    output logic bit_value,
    output logic frame_start,
    output logic sync_lost,
    output logic in_frame
);
    localparam int unsigned OW = $clog2(MIN_PRE_ONES + 1);
    localparam logic [OW-1:0] ONES_REQ = OW'(MIN_PRE_ONES);

    logic       us_tick;
    logic       clean_lvl;
    logic       edge_p;
    logic       timeout;
    bpd_iv_e    iv;

    bpd_state_e state_q, state_d;
    logic [OW-1:0] ones_q;

    logic emit, emit_val, sof_evt, lost_evt, ones_clr, ones_inc;

    bpd_timebase #(.CLK_PER_US(CLK_PER_US)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick)
    );

    bpd_input_cond #(.FILT_TICKS(FILT_TICKS)) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (us_tick),
        .raw_in     (env_in),
        .clean_lvl  (clean_lvl),
        .edge_pulse (edge_p)
    );

    bpd_interval_timer #(
        .HALF_MIN_US (HALF_MIN_US),
        .HALF_MAX_US (HALF_MAX_US),
        .FULL_MIN_US (FULL_MIN_US),
        .FULL_MAX_US (FULL_MAX_US),
        .SILENCE_US  (SILENCE_US)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick  (us_tick),
        .edge_in  (edge_p),
        .iv_class (iv),
        .timeout  (timeout)
    );

    // Next-state and event decode.
    always_comb begin
        state_d  = state_q;
        emit     = 1'b0;
        emit_val = 1'b0;
        sof_evt  = 1'b0;
        lost_evt = 1'b0;
        ones_clr = 1'b0;
        ones_inc = 1'b0;
        if (timeout && state_q != S_WAIT_EDGE) begin
            // silence
            state_d  = S_WAIT_EDGE;
            lost_evt = 1'b1;
            ones_clr = 1'b1;
        end else if (edge_p) begin
            unique case (state_q)
                S_WAIT_EDGE: begin
                    state_d  = S_PRE_CELL;
                    ones_clr = 1'b1;
                end
                S_PRE_CELL: begin
                    if (iv == IV_HALF) begin
                        state_d = S_PRE_MID;
                    end else if (iv == IV_FULL) begin
                        ones_clr = 1'b1;
                        if (ones_q >= ONES_REQ) begin
                            state_d = S_DATA_CELL;
                            emit    = 1'b1;
                            sof_evt = 1'b1;
                        end
                    end else begin
                        lost_evt = 1'b1;
                        ones_clr = 1'b1;
                    end
                end
                S_PRE_MID: begin
                    state_d = S_PRE_CELL;
                    if (iv == IV_HALF) begin
                        ones_inc = 1'b1;
                    end else begin
                        lost_evt = 1'b1;
                        ones_clr = 1'b1;
                    end
                end
                S_DATA_CELL: begin
                    if (iv == IV_HALF) begin
                        state_d = S_DATA_MID;
                    end else if (iv == IV_FULL) begin
                        emit = 1'b1;
                    end else begin
                        state_d  = S_PRE_CELL;
                        lost_evt = 1'b1;
                        ones_clr = 1'b1;
                    end
                end
                S_DATA_MID: begin
                    if (iv == IV_HALF) begin
                        state_d  = S_DATA_CELL;
                        emit     = 1'b1;
                        emit_val = 1'b1;
                    end else begin
                        state_d  = S_PRE_CELL;
                        lost_evt = 1'b1;
                        ones_clr = 1'b1;
                    end
                end
                default: begin
                    state_d  = S_WAIT_EDGE;
                    ones_clr = 1'b1;
                end
            endcase
        end
    end

    // State register and preamble counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_WAIT_EDGE;
            ones_q  <= '0;
        end else begin
            state_q <= state_d;
            if (ones_clr)
                ones_q <= '0;
            else if (ones_inc && ones_q != ONES_REQ)
                ones_q <= ones_q + 1'b1;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_valid   <= 1'b0;
            bit_value   <= 1'b0;
            frame_start <= 1'b0;
            sync_lost   <= 1'b0;
            in_frame    <= 1'b0;
        end else begin
            bit_valid   <= emit;
            bit_value   <= emit_val;
            frame_start <= sof_evt;
            sync_lost   <= lost_evt;
            in_frame    <= (state_d == S_DATA_CELL) || (state_d == S_DATA_MID);
        end
    end
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_valid,
    input logic bit_value,
    input logic frame_start,
    input logic sync_lost,
    input logic in_frame
);
    // R3
    sof_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (bit_valid && !bit_value));

    // R3
    sof_from_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !$past(in_frame));

    // R10
    bit_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> in_frame);

    // R5
    lost_exits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |-> (!in_frame && !bit_valid));

    // R2
    bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R7
    lost_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |=> !sync_lost);
endmodule

bind biphase_sync_decoder bpd_checker u_bpd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid   (bit_valid),
    .bit_value   (bit_value),
    .frame_start (frame_start),
    .sync_lost   (sync_lost),
    .in_frame    (in_frame)
);

// File: tb/biphase_sync_decoder_test.sv
`timescale 1ns/1ps
module biphase_sync_decoder_test;
    localparam int unsigned CPU = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic env = 1'b0;
    logic bit_valid, bit_value, frame_start, sync_lost, in_frame;

    int n_checks = 0;
    int n_errors = 0;
    int rx_n = 0, sof_n = 0, lost_n = 0;
    logic rx_bits [0:511];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    biphase_sync_decoder #(.CLK_PER_US(CPU)) uut (
        .clk(clk), .rst_n(rst_n), .env_in(env),
        .bit_valid(bit_valid), .bit_value(bit_value),
        .frame_start(frame_start), .sync_lost(sync_lost), .in_frame(in_frame)
    );

    always @(negedge clk) begin
        if (bit_valid) begin
            if (rx_n < 512) rx_bits[rx_n] = bit_value;
            rx_n = rx_n + 1;
        end
        if (frame_start) sof_n = sof_n + 1;
        if (sync_lost) lost_n = lost_n + 1;
    end

    typedef struct packed {
        logic [7:0] pre;
        logic [9:0] half_us;
        logic [9:0] full_us;
        logic [7:0] data;
        logic       sof;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'd11, 10'd250, 10'd500, 8'h35, 1'b1},
        '{8'd25, 10'd250, 10'd500, 8'hA6, 1'b1},
        '{8'd4,  10'd250, 10'd500, 8'hFF, 1'b1},
        '{8'd3,  10'd250, 10'd500, 8'h35, 1'b0},
        '{8'd6,  10'd240, 10'd480, 8'h5C, 1'b1},
        '{8'd6,  10'd260, 10'd520, 8'h93, 1'b1},
        '{8'd6,  10'd210, 10'd580, 8'h0F, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    task automatic flip();
        env = ~env;
    endtask

    task automatic send_bit(input logic v, input int h, input int f);
        flip();
        if (v) begin
            wait_us(h); flip(); wait_us(h);
        end else begin
            wait_us(f);
        end
    endtask

    task automatic preamble_and_start(input int n, input int h, input int f);
        for (int i = 0; i < n; i++) send_bit(1'b1, h, f);
        send_bit(1'b0, h, f);
    endtask

    function automatic int rx_word(input int base, input int cnt);
        int w = 0;
        for (int i = 0; i < cnt; i++)
            if (base + i < 512 && rx_bits[base + i]) w = w | (1 << i);
        return w;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        int b0, s0, l0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_us(5);
        // R1 reset state
        chk(!bit_valid && !frame_start && !sync_lost && !in_frame, "R1 outputs after reset",
            {bit_valid, frame_start, sync_lost, in_frame}, 0);
        // R7 no edge since reset: no sync loss
        wait_us(2000);
        chk(lost_n == 0, "R7 idle without edge", lost_n, 0);

        // Table of frames
        for (int v = 0; v < 7; v++) begin
            b0 = rx_n; s0 = sof_n; l0 = lost_n;
            preamble_and_start(VECS[v].pre, VECS[v].half_us, VECS[v].full_us);
            for (int i = 0; i < 8; i++)
                send_bit(VECS[v].data[i], VECS[v].half_us, VECS[v].full_us);
            flip();
            wait_us(20);
            if (VECS[v].sof) begin
                // R3 R9 frame lock
                chk(sof_n - s0 == 1, "R3 frame_start count", sof_n - s0, 1);
                // R2 R10 start + data only, preamble not emitted
                chk(rx_n - b0 == 9, "R10 bit count", rx_n - b0, 9);
                chk(rx_word(b0, 9) == {VECS[v].data, 1'b0}, "R2 R9 bit values",
                    rx_word(b0, 9), int'({VECS[v].data, 1'b0}));
                chk(in_frame == 1'b1, "R2 still in frame", in_frame, 1);
            end else begin
                // R4 short preamble
                chk(sof_n - s0 == 0, "R4 no frame_start", sof_n - s0, 0);
                chk(rx_n - b0 == 0, "R4 no bits", rx_n - b0, 0);
                chk(lost_n - l0 == 0, "R4 no sync_lost", lost_n - l0, 0);
            end
            wait_us(1000);
            // R7 silence ends the frame
            chk(lost_n - l0 == 1, "R7 silence sync_lost", lost_n - l0, 1);
            chk(in_frame == 1'b0, "R7 in_frame cleared", in_frame, 0);
        end

        // R5 out-of-window interval
        b0 = rx_n; l0 = lost_n;
        preamble_and_start(6, 250, 500);
        send_bit(1'b0, 250, 500);
        flip(); wait_us(350); flip();
        wait_us(10);
        chk(lost_n - l0 == 1, "R5 sync_lost on 350us", lost_n - l0, 1);
        chk(in_frame == 1'b0, "R5 in_frame dropped", in_frame, 0);
        chk(rx_n - b0 == 2, "R5 no bit from bad interval", rx_n - b0, 2);
        wait_us(1000);

        // R6 full interval while half pending
        b0 = rx_n; l0 = lost_n;
        preamble_and_start(6, 250, 500);
        flip(); wait_us(250); flip(); wait_us(500); flip();
        wait_us(10);
        chk(lost_n - l0 == 1, "R6 sync_lost", lost_n - l0, 1);
        chk(rx_n - b0 == 1, "R6 no ONE emitted", rx_n - b0, 1);
        chk(in_frame == 1'b0, "R6 in_frame dropped", in_frame, 0);
        wait_us(1000);

        // R7 silence in frame
        l0 = lost_n;
        preamble_and_start(6, 250, 500);
        send_bit(1'b1, 250, 500);
        flip();
        wait_us(10);
        chk(in_frame == 1'b1 && lost_n == l0, "R7 in frame before silence", in_frame, 1);
        wait_us(900);
        chk(lost_n - l0 == 1, "R7 timeout pulse", lost_n - l0, 1);
        chk(in_frame == 1'b0, "R7 in_frame after timeout", in_frame, 0);

        // R8 glitch inside a ZERO cell
        b0 = rx_n; l0 = lost_n;
        preamble_and_start(6, 250, 500);
        flip(); wait_us(250); flip(); wait_us(1); flip(); wait_us(249);
        send_bit(1'b1, 250, 500);
        send_bit(1'b0, 250, 500);
        flip();
        wait_us(10);
        chk(rx_n - b0 == 4, "R8 bit count with glitch", rx_n - b0, 4);
        chk(rx_word(b0, 4) == 4'b0100, "R8 bit values with glitch", rx_word(b0, 4), 4);
        chk(lost_n == l0, "R8 no sync_lost", lost_n - l0, 0);
        wait_us(1000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule